// File: doc/BRIEF.md
# Age-Ordered Wave Schedule Queue

This block holds, for a single execution resource, a short queue of wavefront entries that wait between operand-read scheduling and dispatch. Each entry carries a wave ID, a scalar flag and a two-state operand status: busy while its operands are still being read from the register files, ready once every read it needs has completed. A wave joins the tail of the queue only if the register files grant it read scheduling. Its status is then refreshed every cycle from per-wave completion bitmaps.

Each cycle the block walks the queue from the head and removes the first ready entry whose execution resource reports ready. That wave is presented on a registered pick output. A wave that lost later arbitration can be handed back. It is placed by age, ahead of the first entry with a larger ID, and enters in the ready state. A membership bitmap records every wave that currently owns an instruction in the stage, so a second instruction from the same wave is turned away. The bit is cleared by a delete strobe when the instruction retires. Admissions refused by a register-file grant are tallied in three stall counters.

Top module: `wave_sched_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `q_count`, `pick_vld`, `pick_id`, `adm_ok` and all three stall counters read 0.
- R2: An admission candidate is accepted when `srf_rd_grant` is 1 and either `adm_scalar` is 1 or `vrf_rd_grant` is 1. It is appended at the tail in the busy state, and `adm_ok` is 1 in the following cycle.
- R3: A busy entry is never picked. At every clock edge each remaining entry's status is set to ready if `srf_done[id]` is 1 and either the entry is scalar or `vrf_done[id]` is 1. Otherwise it is set to busy. The new status first affects selection in the next cycle.
- R4: Each cycle, at most one entry is picked: the one nearest the head that is ready and has `rsrc_rdy[id]` set. It leaves the queue, and `pick_vld`/`pick_id` show it one cycle later.
- R5: A candidate whose ID already holds membership is ignored. It is not admitted, `adm_ok` stays 0, and no stall counter moves, whatever the grants.
- R6: Membership starts at admission and persists after the wave is picked. It ends only when `del_valid` names the ID, after which the ID can be admitted again. A delete and an admission in the same cycle are judged against the membership held before that cycle.
- R7: A returned wave (`rin_valid`) is inserted immediately before the first entry whose ID is larger than `rin_id`, or at the tail if there is none. It enters in the ready state, and its membership is not changed.
- R8: When a candidate passes the membership and room checks but is refused by the grants, `stall_any` increments. `stall_vrf` also increments if the candidate is vector and `vrf_rd_grant` is 0. `stall_srf` also increments if `srf_rd_grant` is 0. Both may increment in the same cycle.
- R9: Room is measured after the cycle's pick. A returned wave is dropped if no slot is free. An admission is refused, with no stall count, if no slot is left after the returned wave.
- R10: Within one cycle the order is: pick removal, then age-ordered reinsertion, then tail append of the admitted wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adm_valid | input | 1 | Admission candidate present |
| adm_id | input | ID_W | Candidate wave ID |
| adm_scalar | input | 1 | Candidate instruction is scalar |
| vrf_rd_grant | input | 1 | Vector register file grants read scheduling |
| srf_rd_grant | input | 1 | Scalar register file grants read scheduling |
| vrf_done | input | 2**ID_W | Per-wave vector operand reads complete |
| srf_done | input | 2**ID_W | Per-wave scalar operand reads complete |
| rsrc_rdy | input | 2**ID_W | Per-wave execution resource ready |
| rin_valid | input | 1 | Returned wave present |
| rin_id | input | ID_W | Returned wave ID |
| rin_scalar | input | 1 | Returned wave instruction is scalar |
| del_valid | input | 1 | Retire strobe, clears membership |
| del_id | input | ID_W | Retiring wave ID |
| adm_ok | output | 1 | Candidate of the previous cycle was admitted |
| pick_vld | output | 1 | An entry was picked in the previous cycle |
| pick_id | output | ID_W | Picked wave ID |
| q_count | output | $clog2(DEPTH+1) | Occupied entries |
| stall_any | output | CNT_W | Grant refusals |
| stall_vrf | output | CNT_W | Refusals with vector grant missing |
| stall_srf | output | CNT_W | Refusals with scalar grant missing |

## Verification
Directed sequences come first. Vector and scalar candidates admitted under all four grant combinations separate the vector-check bypass from the counter rules. Done bits are raised for a middle entry and later for a scalar entry, which tells head-of-queue order apart from ready-first selection and shows the one-cycle status lag. Returned waves whose IDs fall below, between, equal to and above the queued IDs are drained in one burst, and the order of the picks reveals the insertion position. A full queue is then hit with a simultaneous pick, return and admission to expose the room and ordering rules. A long random run over sixteen IDs follows, with collisions on membership, deletes and per-wave readiness, compared cycle by cycle against a behavioural queue model.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic {
    ST_BUSY  = 1'b0,
    ST_READY = 1'b1
  } opd_st_e;

  // Operand-side readiness: scalar side always required, vector side only
  // for vector instructions. Used for both grants and completion.
  function automatic logic opd_ready(input logic is_scalar,
                                     input logic vec_ok,
                                     input logic sca_ok);
    return sca_ok && (is_scalar || vec_ok);
  endfunction

endpackage

// File: rtl/wsq_pick.sv
// Lowest-index set bit finder.
module wsq_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wsq_members.sv
// Bitmap of waves that currently own an instruction in the stage.
module wsq_members #(
  parameter int ID_W = 8,
  localparam int NWAVE = 1 << ID_W
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] chk_id,
  output logic            hit
);
  logic [NWAVE-1:0] member_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      member_q <= '0;
    end else begin
      if (clr_en) member_q[clr_id] <= 1'b0;
      if (set_en) member_q[set_id] <= 1'b1;
    end
  end

  assign hit = member_q[chk_id];
endmodule

// File: rtl/wsq_stall_cnt.sv
module wsq_stall_cnt #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (inc) val <= val + 1'b1;
  end
endmodule

// File: rtl/wave_sched_queue.sv
module wave_sched_queue
  import wsq_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int NWAVE = 1 << ID_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             adm_valid,
  input  logic [ID_W-1:0]  adm_id,
  input  logic             adm_scalar,
  input  logic             vrf_rd_grant,
  input  logic             srf_rd_grant,
  input  logic [NWAVE-1:0] vrf_done,
  input  logic [NWAVE-1:0] srf_done,
  input  logic [NWAVE-1:0] rsrc_rdy,
  input  logic             rin_valid,
  input  logic [ID_W-1:0]  rin_id,
  input  logic             rin_scalar,
  input  logic             del_valid,
  input  logic [ID_W-1:0]  del_id,
  output logic             adm_ok,
  output logic             pick_vld,
  output logic [ID_W-1:0]  pick_id,
  output logic [CW-1:0]    q_count,
  output logic [CNT_W-1:0] stall_any,
  output logic [CNT_W-1:0] stall_vrf,
  output logic [CNT_W-1:0] stall_srf
);

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            scalar;
    opd_st_e         st;
  } ent_t;

  ent_t q   [DEPTH];  // registered queue, index 0 = head
  ent_t sh  [DEPTH];  // after pick removal and status refresh
  ent_t ins [DEPTH];  // after age-ordered reinsertion
  ent_t nxt [DEPTH];  // after tail append

  logic [CW-1:0]    cnt_q, cnt_sh, cnt_ins;
  logic [DEPTH-1:0] pick_req, opd_ok, later_gt;
  logic             pick_hit, gt_hit;
  logic [IDX_W-1:0] pick_idx, gt_idx;
  logic [CW-1:0]    rin_pos;
  logic             rin_go, mem_hit, adm_room, adm_grant, adm_gate;
  logic             adm_go, adm_deny;
  ent_t             rin_e, adm_e;
  logic [2:0]       stall_inc;
  logic [CNT_W-1:0] stall_val [3];

  // Per-entry operand completion and pick request
  for (genvar g = 0; g < DEPTH; g++) begin : g_eval
    assign opd_ok[g]   = opd_ready(q[g].scalar, vrf_done[q[g].id],
                                   srf_done[q[g].id]);
    assign pick_req[g] = (CW'(g) < cnt_q) && (q[g].st == ST_READY) &&
                         rsrc_rdy[q[g].id];
  end

  wsq_pick #(.N(DEPTH)) u_pick (
    .req (pick_req),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  assign cnt_sh = cnt_q - CW'(pick_hit);

  // Close the gap left by the pick; refresh each survivor's status
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    logic from_up;
    assign from_up = pick_hit && (pick_idx <= IDX_W'(g));
    if (g < DEPTH - 1) begin : g_mid
      ent_t src;
      logic src_ok;
      assign src    = from_up ? q[g+1] : q[g];
      assign src_ok = from_up ? opd_ok[g+1] : opd_ok[g];
      assign sh[g]  = '{id: src.id, scalar: src.scalar,
                        st: (src_ok ? ST_READY : ST_BUSY)};
    end else begin : g_last
      assign sh[g] = '{id: q[g].id, scalar: q[g].scalar,
                       st: (opd_ok[g] ? ST_READY : ST_BUSY)};
    end
  end

  // Age-ordered reinsertion point: first entry with a larger ID
  for (genvar g = 0; g < DEPTH; g++) begin : g_gt
    assign later_gt[g] = (CW'(g) < cnt_sh) && (sh[g].id > rin_id);
  end

  wsq_pick #(.N(DEPTH)) u_pos (
    .req (later_gt),
    .hit (gt_hit),
    .idx (gt_idx)
  );

  assign rin_go  = rin_valid && (cnt_sh < CW'(DEPTH));
  assign rin_pos = gt_hit ? CW'(gt_idx) : cnt_sh;
  assign rin_e   = '{id: rin_id, scalar: rin_scalar, st: ST_READY};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ins
    if (g == 0) begin : g_head
      assign ins[g] = (rin_go && rin_pos == '0) ? rin_e : sh[g];
    end else begin : g_body
      assign ins[g] = (rin_go && rin_pos == CW'(g)) ? rin_e :
                      (rin_go && rin_pos <  CW'(g)) ? sh[g-1] : sh[g];
    end
  end

  assign cnt_ins = cnt_sh + CW'(rin_go);

  // Admission
  wsq_members #(.ID_W(ID_W)) u_members (
    .clk    (clk),
    .rst    (rst),
    .set_en (adm_go),
    .set_id (adm_id),
    .clr_en (del_valid),
    .clr_id (del_id),
    .chk_id (adm_id),
    .hit    (mem_hit)
  );

  assign adm_room  = cnt_ins < CW'(DEPTH);
  assign adm_grant = opd_ready(adm_scalar, vrf_rd_grant, srf_rd_grant);
  assign adm_gate  = adm_valid && !mem_hit && adm_room;
  assign adm_go    = adm_gate && adm_grant;
  assign adm_deny  = adm_gate && !adm_grant;
  assign adm_e     = '{id: adm_id, scalar: adm_scalar, st: ST_BUSY};

  for (genvar g = 0; g < DEPTH; g++) begin : g_app
    assign nxt[g] = (adm_go && cnt_ins == CW'(g)) ? adm_e : ins[g];
  end

  // Stall counters: [0] any refusal, [1] vector grant, [2] scalar grant
  assign stall_inc = {adm_deny && !srf_rd_grant,
                      adm_deny && !adm_scalar && !vrf_rd_grant,
                      adm_deny};

  for (genvar k = 0; k < 3; k++) begin : g_stall
    wsq_stall_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (stall_inc[k]),
      .val (stall_val[k])
    );
  end

  assign stall_any = stall_val[0];
  assign stall_vrf = stall_val[1];
  assign stall_srf = stall_val[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      cnt_q    <= '0;
      pick_vld <= 1'b0;
      pick_id  <= '0;
      adm_ok   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
      cnt_q    <= cnt_ins + CW'(adm_go);
      pick_vld <= pick_hit;
      pick_id  <= pick_hit ? q[pick_idx].id : '0;
      adm_ok   <= adm_go;
    end
  end

  assign q_count = cnt_q;

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int NWAVE = 1 << ID_W,
  localparam int CW    = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rst,
  input logic             adm_valid,
  input logic             adm_scalar,
  input logic             vrf_rd_grant,
  input logic             srf_rd_grant,
  input logic [NWAVE-1:0] rsrc_rdy,
  input logic             adm_ok,
  input logic             pick_vld,
  input logic [ID_W-1:0]  pick_id,
  input logic [CW-1:0]    q_count,
  input logic [CNT_W-1:0] stall_any,
  input logic [CNT_W-1:0] stall_vrf,
  input logic [CNT_W-1:0] stall_srf
);
  logic [NWAVE-1:0] rsrc_prev;
  always_ff @(posedge clk) rsrc_prev <= rsrc_rdy;

  // R9
  q_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(q_count) <= DEPTH);

  // R4
  pick_resource_chk: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> rsrc_prev[pick_id]);

  // R2
  admit_grant_chk: assert property (@(posedge clk) disable iff (rst)
    adm_ok |-> ($past(adm_valid) && $past(srf_rd_grant) &&
                ($past(adm_scalar) || $past(vrf_rd_grant))));

  // R8
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_any != $past(stall_any)) |-> (stall_any == $past(stall_any) + 1'b1));

  // R8
  stall_link_chk: assert property (@(posedge clk) disable iff (rst)
    ((stall_vrf != $past(stall_vrf)) || (stall_srf != $past(stall_srf)))
      |-> (stall_any != $past(stall_any)));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(q_count) <= int'($past(q_count)) + 2) &&
    (int'(q_count) + 1 >= int'($past(q_count))));

endmodule

bind wave_sched_queue wsq_checker #(
  .ID_W (ID_W),
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .adm_valid    (adm_valid),
  .adm_scalar   (adm_scalar),
  .vrf_rd_grant (vrf_rd_grant),
  .srf_rd_grant (srf_rd_grant),
  .rsrc_rdy     (rsrc_rdy),
  .adm_ok       (adm_ok),
  .pick_vld     (pick_vld),
  .pick_id      (pick_id),
  .q_count      (q_count),
  .stall_any    (stall_any),
  .stall_vrf    (stall_vrf),
  .stall_srf    (stall_srf)
);

// File: tb/wave_sched_queue_tb_top.sv
module wave_sched_queue_tb_top;
  localparam int ID_W  = 8;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;
  localparam int NWAVE = 1 << ID_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic             adm_valid, adm_scalar, vrf_rd_grant, srf_rd_grant;
  logic [ID_W-1:0]  adm_id;
  logic [NWAVE-1:0] vrf_done, srf_done, rsrc_rdy;
  logic             rin_valid, rin_scalar, del_valid;
  logic [ID_W-1:0]  rin_id, del_id;
  logic             adm_ok, pick_vld;
  logic [ID_W-1:0]  pick_id;
  logic [CW-1:0]    q_count;
  logic [CNT_W-1:0] stall_any, stall_vrf, stall_srf;

  always #10 clk = ~clk;  // 50 MHz

  wave_sched_queue #(.ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .adm_valid(adm_valid), .adm_id(adm_id), .adm_scalar(adm_scalar),
    .vrf_rd_grant(vrf_rd_grant), .srf_rd_grant(srf_rd_grant),
    .vrf_done(vrf_done), .srf_done(srf_done), .rsrc_rdy(rsrc_rdy),
    .rin_valid(rin_valid), .rin_id(rin_id), .rin_scalar(rin_scalar),
    .del_valid(del_valid), .del_id(del_id),
    .adm_ok(adm_ok), .pick_vld(pick_vld), .pick_id(pick_id),
    .q_count(q_count), .stall_any(stall_any), .stall_vrf(stall_vrf),
    .stall_srf(stall_srf)
  );

  int    checks = 0;
  int    errors = 0;
  bit    ended  = 0;
  string tag    = "R1";

  // Behavioural model
  int m_id[$];
  bit m_sc[$];
  bit m_rdy[$];
  bit m_mem[NWAVE];
  int e_ok, e_pv, e_pid, e_any, e_vrf, e_srf;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int pos;
    bit hit;
    e_pv = 0; e_pid = 0;
    for (int i = 0; i < m_id.size(); i++) begin
      if (m_rdy[i] && rsrc_rdy[m_id[i]]) begin
        e_pv = 1; e_pid = m_id[i];
        m_id.delete(i); m_sc.delete(i); m_rdy.delete(i);
        break;
      end
    end
    for (int i = 0; i < m_id.size(); i++)
      m_rdy[i] = srf_done[m_id[i]] && (m_sc[i] || vrf_done[m_id[i]]);
    if (rin_valid && m_id.size() < DEPTH) begin
      pos = m_id.size();
      for (int i = 0; i < m_id.size(); i++)
        if (m_id[i] > int'(rin_id)) begin pos = i; break; end
      m_id.insert(pos, int'(rin_id)); m_sc.insert(pos, rin_scalar);
      m_rdy.insert(pos, 1'b1);
    end
    e_ok = 0;
    hit = m_mem[adm_id];
    if (adm_valid && !hit && m_id.size() < DEPTH) begin
      if (srf_rd_grant && (adm_scalar || vrf_rd_grant)) begin
        m_id.push_back(int'(adm_id)); m_sc.push_back(adm_scalar);
        m_rdy.push_back(1'b0);
        e_ok = 1;
      end else begin
        e_any++;
        if (!adm_scalar && !vrf_rd_grant) e_vrf++;
        if (!srf_rd_grant) e_srf++;
      end
    end
    if (del_valid) m_mem[del_id] = 1'b0;
    if (e_ok == 1) m_mem[adm_id] = 1'b1;
  endtask

  task automatic compare_all();
    check("adm_ok", int'(adm_ok), e_ok);
    check("pick_vld", int'(pick_vld), e_pv);
    if (e_pv == 1) check("pick_id", int'(pick_id), e_pid);
    check("q_count", int'(q_count), m_id.size());
    check("stall_any", int'(stall_any), e_any);
    check("stall_vrf", int'(stall_vrf), e_vrf);
    check("stall_srf", int'(stall_srf), e_srf);
  endtask

  task automatic clear_pulses();
    adm_valid = 0; rin_valid = 0; del_valid = 0;
    adm_scalar = 0; rin_scalar = 0;
    vrf_rd_grant = 1; srf_rd_grant = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    compare_all();
    clear_pulses();
  endtask

  task automatic admit(int id, bit sc, bit vg, bit sg);
    adm_valid = 1; adm_id = ID_W'(id); adm_scalar = sc;
    vrf_rd_grant = vg; srf_rd_grant = sg;
  endtask

  task automatic give_back(int id);
    rin_valid = 1; rin_id = ID_W'(id); rin_scalar = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL %s watchdog expired actual=0 expected=1", tag);
    finish_run();
  end

  initial begin
    rst = 1;
    adm_id = '0; rin_id = '0; del_id = '0;
    vrf_done = '0; srf_done = '0; rsrc_rdy = '1;
    clear_pulses();
    for (int i = 0; i < NWAVE; i++) m_mem[i] = 0;
    e_any = 0; e_vrf = 0; e_srf = 0; e_ok = 0; e_pv = 0; e_pid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("q_count", int'(q_count), 0);
    check("pick_vld", int'(pick_vld), 0);
    check("adm_ok", int'(adm_ok), 0);
    check("stall_any", int'(stall_any), 0);
    check("stall_vrf", int'(stall_vrf), 0);
    check("stall_srf", int'(stall_srf), 0);
    rst = 0;

    // R2: admissions enter busy at the tail
    tag = "R2";
    admit(5, 0, 1, 1); tick();
    admit(9, 0, 1, 1); tick();
    admit(12, 1, 0, 1); tick();
    // R3: busy entries are not picked
    tag = "R3";
    tick(); tick();
    vrf_done[9] = 1; srf_done[9] = 1;
    tick(); tick();
    srf_done[12] = 1;      // scalar needs no vector completion
    tick(); tick();
    vrf_done = '0; srf_done = '0;

    // R8: grant refusals
    tag = "R8";
    admit(20, 0, 0, 1); tick();
    admit(20, 0, 1, 0); tick();
    admit(20, 0, 0, 0); tick();
    admit(21, 1, 0, 0); tick();
    tag = "R2";
    admit(21, 1, 0, 1); tick();

    // R5: duplicates are ignored
    tag = "R5";
    admit(5, 0, 1, 1); tick();
    admit(5, 0, 0, 0); tick();
    admit(9, 0, 1, 1); tick();   // picked but still a member

    // R6: delete releases membership
    tag = "R6";
    del_valid = 1; del_id = 9; tick();
    admit(9, 0, 1, 1); tick();
    admit(12, 1, 1, 1); del_valid = 1; del_id = 12; tick();
    admit(12, 1, 1, 1); tick();

    // R7: age-ordered reinsertion, drained to reveal order
    tag = "R7";
    rsrc_rdy = '0;
    give_back(7); tick();
    give_back(30); tick();
    give_back(3); tick();
    rsrc_rdy = '1;
    give_back(5); tick();
    rsrc_rdy = '0;
    give_back(5); tick();
    vrf_done = '1; srf_done = '1;
    tick();
    rsrc_rdy = '1;
    repeat (10) tick();
    vrf_done = '0; srf_done = '0;

    // R4: resource check skips older ready entries
    tag = "R4";
    for (int i = 0; i < NWAVE; i++) begin
      if (m_mem[i]) begin del_valid = 1; del_id = ID_W'(i); tick(); end
    end
    rsrc_rdy = '0;
    admit(50, 0, 1, 1); tick();
    admit(51, 0, 1, 1); tick();
    admit(52, 0, 1, 1); tick();
    vrf_done = '1; srf_done = '1; tick();
    rsrc_rdy[52] = 1; tick(); tick();
    rsrc_rdy = '1; tick(); tick(); tick();
    vrf_done = '0; srf_done = '0;

    // R9: full queue
    tag = "R9";
    rsrc_rdy = '0;
    for (int i = 0; i < DEPTH; i++) begin admit(60 + i, 0, 1, 1); tick(); end
    admit(80, 0, 1, 1); tick();
    admit(81, 0, 0, 0); tick();
    give_back(2); tick();

    // R10: pick, return and admit in one cycle
    tag = "R10";
    vrf_done[60] = 1; srf_done[60] = 1; tick();
    rsrc_rdy[60] = 1;
    give_back(1); admit(82, 0, 1, 1); tick();
    rsrc_rdy = '0;
    vrf_done[61] = 1; srf_done[61] = 1; tick();
    rsrc_rdy[61] = 1;
    admit(83, 0, 1, 1); tick();
    rsrc_rdy = '1; vrf_done = '1; srf_done = '1;
    repeat (12) tick();

    // Random traffic over a small ID space
    tag = "R4";
    for (int c = 0; c < 4000; c++) begin
      vrf_done = '0; srf_done = '0; rsrc_rdy = '0;
      for (int w = 0; w < 16; w++) begin
        vrf_done[w] = ($urandom_range(0, 3) != 0);
        srf_done[w] = ($urandom_range(0, 3) != 0);
        rsrc_rdy[w] = ($urandom_range(0, 2) != 0);
      end
      if ($urandom_range(0, 1) == 1)
        admit($urandom_range(0, 15), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) != 0));
      if ($urandom_range(0, 4) == 0) begin
        rin_valid = 1; rin_id = ID_W'($urandom_range(0, 15));
        rin_scalar = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 2) == 0) begin
        del_valid = 1; del_id = ID_W'($urandom_range(0, 15));
      end
      tick();
    end
    finish_run();
  end
endmodule